// File: doc/BRIEF.md
# UART Register File with Busy-Detect Interrupt

This block is the register and interrupt layer of a 16550-style serial port. Adds a busy-detect extension. Software reaches it over a 32-bit register bus. Each 8-bit register sits on its own 4-byte word, so the word index comes from address bits [4:2]. A one-entry transmit holding register feeds a serializer. A deserializer fills a one-entry receive buffer. Both run from a 16x oversampling tick that is derived from a 16-bit divisor.

The extension guards the line control register. While any character is pending, shifting out or arriving, a write to that register is dropped. The write raises a busy-detect interrupt, which stays set until software reads the status register. A handler that never reads the status register therefore sees the interrupt line stay high without end. The correct driver sequence is: poll the busy bit, then write the line control register.

Top module: `uart_busy_regs`

## Requirements
- R1: Registers occupy word indices taken from address bits [4:2]: 0 data/divisor-low, 1 interrupt-enable/divisor-high, 2 interrupt identity (read), 3 line control, 5 line status, 7 UART status. Read data carries the register in bits [7:0], and bits [31:8] read as zero.
- R2: Line control bit 7 (divisor access) set makes indices 0 and 1 read and write divisor bits [7:0] and [15:8]. The data buffer and interrupt enables are left untouched.
- R3: A line control write while busy leaves the line control register unchanged and sets the busy-detect condition.
- R4: Busy-detect drives interrupt identity code 0x07 and raises irq whatever the enable bits hold. It persists until a read of the UART status register clears it.
- R5: UART status bit 0 reads 1 while a holding-register byte waits, while a character shifts out, and while a character is being received. Otherwise it reads 0.
- R6: Interrupt identity priority, highest first: 0x04 received data (enable bit 0 with data ready), 0x02 transmit holding empty (enable bit 1), 0x07 busy-detect, 0x01 none. irq is high whenever the code is not 0x01.
- R7: Reading identity while it shows 0x02 clears the holding-empty cause. A data write also clears it. The cause re-arms when a written byte moves into the shifter.
- R8: Frames are 8N1 and LSB first. Line status bit 0 is data ready and is cleared by reading index 0 with divisor access off. Bit 5 means holding register empty. Bit 6 means holding register empty and transmitter idle.
- R9: Line control bit 6 (break) drives txd low while set, and txd returns to idle high when it clears.
- R10: The oversampling tick fires once every divisor clocks, with 16 ticks per bit. A divisor of 0 stops the tick and freezes both the serializer and the deserializer.
- R11: After reset: line control 0x00, enables 0, divisor 0, identity 0x01, line status 0x60, UART status 0x00, txd high, irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request, one cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data, bits [7:0] used |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| txd | output | 1 | Serial transmit line, registered |
| rxd | input | 1 | Serial receive line, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 5-bit address, 8-bit characters, a 16-bit divisor and 16x oversampling. The divisor is programmed to 1, so a frame takes 160 clocks and many looped-back random bytes fit in a short run. Switching the divisor to 2 and then to 0 brings the bit-period scaling and the stopped-tick freeze within reach. Looping txd back to rxd holds the port busy for long stretches. That makes it possible to force the rejected line control write and to stack all three interrupt causes at once, so the priority order shows.

// File: rtl/uart_bd_pkg.sv
package uart_bd_pkg;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] IDX_DATA  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_IEN   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_IID   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LCTL  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_LSTAT = 3'd5;
  localparam logic [IDX_W-1:0] IDX_USTAT = 3'd7;

  localparam logic [3:0] IID_NONE = 4'h1;
  localparam logic [3:0] IID_RDA  = 4'h4;
  localparam logic [3:0] IID_THRE = 4'h2;
  localparam logic [3:0] IID_BUSY = 4'h7;

  localparam int LCTL_DLAB_BIT = 7;
  localparam int LCTL_BRK_BIT  = 6;
endpackage

// File: rtl/uart_bd_baud.sv
module uart_bd_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || divisor == '0) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= divisor - DIV_W'(1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_bd_tx.sv
module uart_bd_tx #(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  output logic              taken,
  output logic              active,
  output logic              line
);
  localparam int FRAME = DATA_W + 2;
  localparam int BIT_W = $clog2(FRAME);
  localparam int OS_W  = $clog2(OS);

  logic [FRAME-1:0] shreg_q;
  logic [BIT_W-1:0] bit_q;
  logic [OS_W-1:0]  os_q;

  assign taken = !active && load_valid;
  assign line  = active ? shreg_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      shreg_q <= '1;
      bit_q   <= '0;
      os_q    <= '0;
    end else if (taken) begin
      active  <= 1'b1;
      shreg_q <= {1'b1, load_data, 1'b0};
      bit_q   <= '0;
      os_q    <= '0;
    end else if (active && tick) begin
      if (os_q == OS_W'(OS - 1)) begin
        os_q    <= '0;
        shreg_q <= {1'b1, shreg_q[FRAME-1:1]};
        if (bit_q == BIT_W'(FRAME - 1)) active <= 1'b0;
        else bit_q <= bit_q + BIT_W'(1);
      end else begin
        os_q <= os_q + OS_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_bd_rx.sv
module uart_bd_rx #(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd_sync,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              active
);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam int OS_W  = $clog2(OS);

  logic             in_start_q;
  logic [BIT_W-1:0] bit_q;
  logic [OS_W-1:0]  os_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      in_start_q <= 1'b0;
      bit_q      <= '0;
      os_q       <= '0;
      data       <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (!rxd_sync) begin
          active     <= 1'b1;
          in_start_q <= 1'b1;
          os_q       <= '0;
          bit_q      <= '0;
        end
      end else if (tick) begin
        if (in_start_q) begin
          if (os_q == OS_W'(OS / 2 - 1)) begin
            os_q       <= '0;
            in_start_q <= 1'b0;
            if (rxd_sync) active <= 1'b0;
          end else begin
            os_q <= os_q + OS_W'(1);
          end
        end else if (os_q == OS_W'(OS - 1)) begin
          os_q <= '0;
          if (bit_q == BIT_W'(DATA_W)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            data  <= {rxd_sync, data[DATA_W-1:1]};
            bit_q <= bit_q + BIT_W'(1);
          end
        end else begin
          os_q <= os_q + OS_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_busy_regs.sv
module uart_busy_regs
  import uart_bd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);
  logic [IDX_W-1:0]  idx;
  logic              wr, rd, dlab, busy;
  logic [7:0]        lcr_q;
  logic [1:0]        ier_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] thr_q, rbr_q;
  logic              thr_full_q, dr_q, thre_pend_q, busy_int_q;
  logic              rx_s1_q, rx_s2_q;
  logic              tick, tx_taken, tx_active, tx_line;
  logic              rx_done, rx_active;
  logic [DATA_W-1:0] rx_data;
  logic [3:0]        iid;
  logic [7:0]        rd_byte;
  logic              lcr_wr, usr_rd;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata[31:8], bus_addr[1:0]};
  assign idx    = bus_addr[IDX_W+1:2];
  assign wr     = bus_valid && bus_write;
  assign rd     = bus_valid && !bus_write;
  assign dlab   = lcr_q[LCTL_DLAB_BIT];
  assign busy   = thr_full_q || tx_active || rx_active;
  assign lcr_wr = wr && idx == IDX_LCTL;
  assign usr_rd = rd && idx == IDX_USTAT;

  uart_bd_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .divisor(div_q), .tick(tick));

  uart_bd_tx #(.DATA_W(DATA_W), .OS(OS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .load_valid(thr_full_q),
    .load_data(thr_q), .taken(tx_taken), .active(tx_active), .line(tx_line));

  uart_bd_rx #(.DATA_W(DATA_W), .OS(OS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd_sync(rx_s2_q),
    .done(rx_done), .data(rx_data), .active(rx_active));

  always_comb begin
    if (ier_q[0] && dr_q)                              iid = IID_RDA;
    else if (ier_q[1] && thre_pend_q && !thr_full_q)   iid = IID_THRE;
    else if (busy_int_q)                               iid = IID_BUSY;
    else                                               iid = IID_NONE;
  end
  assign irq = (iid != IID_NONE);

  always_comb begin
    case (idx)
      IDX_DATA:  rd_byte = dlab ? div_q[7:0] : 8'(rbr_q);
      IDX_IEN:   rd_byte = dlab ? 8'(div_q[DIV_W-1:8]) : {6'd0, ier_q};
      IDX_IID:   rd_byte = {4'd0, iid};
      IDX_LCTL:  rd_byte = lcr_q;
      IDX_LSTAT: rd_byte = {1'b0, !thr_full_q && !tx_active, !thr_full_q, 4'd0, dr_q};
      IDX_USTAT: rd_byte = {7'd0, busy};
      default:   rd_byte = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1_q <= 1'b1;
      rx_s2_q <= 1'b1;
      txd     <= 1'b1;
    end else begin
      rx_s1_q <= rxd;
      rx_s2_q <= rx_s1_q;
      txd     <= lcr_q[LCTL_BRK_BIT] ? 1'b0 : tx_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q       <= '0;
      ier_q       <= '0;
      div_q       <= '0;
      thr_q       <= '0;
      thr_full_q  <= 1'b0;
      rbr_q       <= '0;
      dr_q        <= 1'b0;
      thre_pend_q <= 1'b1;
      busy_int_q  <= 1'b0;
      bus_rdata   <= '0;
    end else begin
      if (rd) begin
        bus_rdata <= {24'd0, rd_byte};
        if (idx == IDX_DATA && !dlab) dr_q <= 1'b0;
        if (idx == IDX_IID && iid == IID_THRE) thre_pend_q <= 1'b0;
        if (idx == IDX_USTAT) busy_int_q <= 1'b0;
      end
      if (tx_taken) begin
        thr_full_q  <= 1'b0;
        thre_pend_q <= 1'b1;
      end
      if (rx_done) begin
        rbr_q <= rx_data;
        dr_q  <= 1'b1;
      end
      if (wr) begin
        case (idx)
          IDX_DATA:
            if (dlab) div_q[7:0] <= bus_wdata[7:0];
            else begin
              thr_q       <= bus_wdata[DATA_W-1:0];
              thr_full_q  <= 1'b1;
              thre_pend_q <= 1'b0;
            end
          IDX_IEN:
            if (dlab) div_q[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
            else ier_q <= bus_wdata[1:0];
          IDX_LCTL:
            if (busy) busy_int_q <= 1'b1;
            else lcr_q <= bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_busy_regs_chk.sv
module uart_busy_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       txd,
  input logic       irq,
  input logic       busy,
  input logic [7:0] lcr,
  input logic       busy_int,
  input logic       lcr_wr,
  input logic       usr_rd
);
  AST_LCR_KEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (lcr_wr && busy) |=> $stable(lcr)); // R3
  AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (lcr_wr && busy) |=> busy_int); // R3
  AST_BUSY_INT_IRQ: assert property (@(posedge clk) disable iff (rst)
    busy_int |-> irq); // R4
  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    usr_rd |=> !busy_int); // R4
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(lcr[6]) |-> !txd); // R9
endmodule

bind uart_busy_regs uart_busy_regs_chk u_chk (
  .clk(clk), .rst(rst), .txd(txd), .irq(irq), .busy(busy), .lcr(lcr_q),
  .busy_int(busy_int_q), .lcr_wr(lcr_wr), .usr_rd(usr_rd));

// File: tb/uart_busy_regs_tb.sv
`timescale 1ns/1ps
module uart_busy_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd, irq;
  logic        lb = 1'b0;
  logic        rx_drv = 1'b1;
  logic        rxd;
  int          checks = 0, fails = 0;

  assign rxd = lb ? txd : rx_drv;
  always #2 clk = ~clk;

  uart_busy_regs u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .irq(irq));

  localparam logic [2:0] I_DATA = 3'd0, I_IEN = 3'd1, I_IID = 3'd2,
                         I_LCTL = 3'd3, I_LSTAT = 3'd5, I_USTAT = 3'd7;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: act timeout exp completion");
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = {i, 2'b00};
    bus_wdata = {24'hA5C3F0, d};
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] q);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = {i, 2'b00};
    @(negedge clk);
    q = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_dr();
    logic [31:0] q;
    for (int n = 0; n < 1000; n++) begin
      rd(I_LSTAT, q);
      if (q[0]) break;
    end
  endtask

  task automatic wait_idle();
    logic [31:0] q;
    for (int n = 0; n < 1000; n++) begin
      rd(I_USTAT, q);
      if (q[0] == 1'b0) break;
    end
  endtask

  task automatic set_div(input logic [15:0] d);
    wr(I_LCTL, 8'h83);
    wr(I_DATA, d[7:0]);
    wr(I_IEN, d[15:8]);
    wr(I_LCTL, 8'h03);
  endtask

  task automatic low_len(output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!txd) break;
    end
    while (!txd && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] rand_byte();
    return 8'($urandom_range(255, 0));
  endfunction

  initial begin
    logic [31:0] q;
    logic [7:0]  b;
    int          n;
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state, R1 upper bits zero
    rd(I_IID, q);   chk("R11 identity after reset (R1 upper zero)", q, 32'h1);
    rd(I_LSTAT, q); chk("R11 line status", q, 32'h60);
    rd(I_USTAT, q); chk("R11 uart status", q, 32'h0);
    rd(I_LCTL, q);  chk("R11 line control", q, 32'h0);
    chk("R11 txd idle", {31'd0, txd}, 32'h1);
    chk("R11 irq low", {31'd0, irq}, 32'h0);

    // R2 divisor access
    wr(I_LCTL, 8'h83);
    wr(I_DATA, 8'h01);
    wr(I_IEN, 8'h00);
    rd(I_DATA, q); chk("R2 divisor low readback", q, 32'h01);
    rd(I_IEN, q);  chk("R2 divisor high readback", q, 32'h00);
    wr(I_LCTL, 8'h03);
    rd(I_LCTL, q); chk("R1 line control readback", q, 32'h03);
    rd(I_IEN, q);  chk("R2 enables untouched by divisor write", q, 32'h0);
    rd(I_LSTAT, q); chk("R2 no data ready from divisor write", {31'd0, q[0]}, 32'h0);

    // R8 R5 random loopback
    lb = 1'b1;
    for (int k = 0; k < 6; k++) begin
      b = rand_byte();
      wr(I_DATA, b);
      rd(I_USTAT, q); chk("R5 busy during transmit", q, 32'h1);
      wait_dr();
      rd(I_DATA, b == b ? q : q); chk("R8 received byte", q, {24'd0, b});
      rd(I_LSTAT, q); chk("R8 data ready cleared by read", {31'd0, q[0]}, 32'h0);
      wait_idle();
      rd(I_USTAT, q); chk("R5 idle after frame", q, 32'h0);
    end

    // R10 bit period at divisor 1
    wr(I_DATA, 8'h01);
    low_len(n); chk("R10 start bit length div1", n, 16);
    wait_dr(); rd(I_DATA, q); wait_idle();

    // R3 R4 busy-detect
    wr(I_DATA, 8'h5A);
    wr(I_LCTL, 8'h43);
    rd(I_LCTL, q); chk("R3 line control kept when busy", q, 32'h03);
    rd(I_IID, q);  chk("R4 busy-detect identity", q, 32'h07);
    chk("R4 irq with enables off", {31'd0, irq}, 32'h1);
    repeat (50) @(negedge clk);
    rd(I_IID, q);  chk("R4 busy-detect persists", q, 32'h07);
    rd(I_USTAT, q);
    rd(I_IID, q);  chk("R4 cleared by status read", q, 32'h01);
    chk("R4 irq low after clear", {31'd0, irq}, 32'h0);
    wait_dr(); rd(I_DATA, q); chk("R8 byte during busy test", q, 32'h5A);
    wait_idle();

    // R9 break
    lb = 1'b0;
    wr(I_LCTL, 8'h43);
    @(negedge clk);
    chk("R9 txd low in break", {31'd0, txd}, 32'h0);
    rd(I_LCTL, q); chk("R3 line control applied when idle", q, 32'h43);
    wr(I_LCTL, 8'h03);
    @(negedge clk);
    chk("R9 txd high after break", {31'd0, txd}, 32'h1);
    lb = 1'b1;

    // R6 R7 priority and holding-empty
    wr(I_IEN, 8'h03);
    rd(I_IID, q); chk("R6 holding empty shown", q, 32'h02);
    rd(I_IID, q); chk("R7 holding empty cleared by identity read", q, 32'h01);
    b = rand_byte();
    wr(I_DATA, b);
    wr(I_LCTL, 8'h03);
    rd(I_IID, q); chk("R6 holding empty over busy-detect", q, 32'h02);
    rd(I_IID, q); chk("R6 busy-detect lowest cause", q, 32'h07);
    wait_dr();
    rd(I_IID, q); chk("R6 received data highest", q, 32'h04);
    rd(I_DATA, q); chk("R8 byte in priority test", q, {24'd0, b});
    rd(I_IID, q); chk("R6 back to busy-detect", q, 32'h07);
    rd(I_USTAT, q);
    wait_idle();
    rd(I_IID, q); chk("R6 no cause", q, 32'h01);
    wr(I_DATA, 8'hC3);
    wait_dr(); rd(I_DATA, q);
    rd(I_IID, q); chk("R7 holding empty re-armed", q, 32'h02);
    wait_idle();
    wr(I_IEN, 8'h00);

    // R10 divisor 2
    set_div(16'd2);
    wr(I_DATA, 8'h01);
    low_len(n); chk("R10 start bit length div2", n, 32);
    wait_dr(); rd(I_DATA, q); chk("R10 byte at div2", q, 32'h01);
    wait_idle();

    // R10 divisor 0 freezes
    set_div(16'd0);
    wr(I_DATA, 8'h55);
    repeat (300) @(negedge clk);
    rd(I_USTAT, q); chk("R10 frozen transmit stays busy", q, 32'h1);
    chk("R10 line frozen on start bit", {31'd0, txd}, 32'h0);
    rd(I_LSTAT, q); chk("R10 no data at divisor 0", {31'd0, q[0]}, 32'h0);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(I_IID, q); chk("R11 identity after second reset", q, 32'h1);
    chk("R11 txd after second reset", {31'd0, txd}, 32'h1);
    summary();
  end
endmodule